// File: doc/BRIEF.md
# Instruction Store Loader with Parity Check

This block is the host-facing write path into an engine's instruction store. The host reaches it through three registers. An index register selects the store entry and turns load mode on or off. A low data word holds instruction bits 31:0. A high data word holds instruction bits 39:32 and the two parity bits. A write to the low word is only held in a latch. A write to the high word joins the latched low word to the new high bits, checks both parity bits, stores the 42-bit word at the current index and then steps the index forward. When the index passes the last entry it wraps to zero.

Host requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A write produces no response. A read produces one response on the `rsp_valid`/`rsp_ready` channel. While a read response waits for `rsp_ready`, the block holds that response steady and drops `req_ready`, so no new request is accepted. The engine side reads the store through a plain registered port.

Top module: `isl_loader`

## Requirements
- R1: Registers are decoded at byte offsets 0x000 (index), 0x004 (low data) and 0x008 (high data). A write to any other offset changes neither the index nor the store.
- R2: A write to the index register copies data bit 31 into load mode and the low log2(DEPTH) bits into the index. A read of the index register returns load mode in bit 31 and the index in the low bits, with all other bits zero.
- R3: In load mode, a write to the low data word only latches the value. The store entry at the index and the index itself stay unchanged.
- R4: In load mode, a write to the high data word stores the 42-bit word {data[9], data[8], data[7:0], latched low word} at the current index. The stored word is visible on `sr_data` one cycle after `sr_idx` selects it.
- R5: Each high-word write in load mode increments the index by one.
- R6: A high-word write at index DEPTH-1 wraps the index to 0 and keeps load mode, so a read of the index register returns 0x80000000.
- R7: Writing 0 to the index register leaves load mode. Outside load mode, writes to either data word leave the store and the index unchanged.
- R8: Bit 40 must be the even parity of instruction bits 19:0, and bit 41 must be the even parity of bits 39:20. If a committed word fails either check, `par_err` is set and stays set until reset, and the word is still stored as written.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds its value.
- R10: After reset, load mode is off, the index is 0, `par_err` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read response data |
| load_mode | output | 1 | Load mode active |
| par_err | output | 1 | Sticky parity mismatch flag |
| sr_idx | input | log2(DEPTH) | Store read index |
| sr_data | output | 42 | Store word, registered |

## Verification
A write updates the index, the load mode flag, the store and `par_err` on the edge that accepts it. These results are sampled at the falling edge that follows, or later. A read response appears one edge after the read is accepted. The scoreboard pops the expected value at the first falling edge where both `rsp_valid` and `rsp_ready` are high. Store contents go through the registered read port, so the bench drives `sr_idx` at a falling edge, lets one rising edge pass, and compares at the next falling edge.

// File: rtl/isl_pkg.sv
package isl_pkg;
  localparam int WORD_W = 32;
  localparam int INSN_W = 40;
  localparam int STORE_W = INSN_W + 2;
  localparam int HALF_W = 20;
  localparam logic [11:0] OFS_INDEX = 12'h000;
  localparam logic [11:0] OFS_LOW = 12'h004;
  localparam logic [11:0] OFS_HIGH = 12'h008;
  localparam int MODE_BIT = 31;
  typedef logic [STORE_W-1:0] store_word_t;

  function automatic logic even_par(input logic [HALF_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/isl_regs.sv
module isl_regs import isl_pkg::*; #(
  parameter int DEPTH = 512,
  parameter int AW = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_ofs,
  input  logic [WORD_W-1:0] wr_data,
  output logic              mode,
  output logic [IDX_W-1:0]  idx,
  output logic              commit,
  output store_word_t       commit_word
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [WORD_W-1:0] low_q;
  logic sel_index, sel_low, sel_high;

  assign sel_index = wr_en && (wr_ofs == AW'(OFS_INDEX));
  assign sel_low   = wr_en && (wr_ofs == AW'(OFS_LOW));
  assign sel_high  = wr_en && (wr_ofs == AW'(OFS_HIGH));

  assign commit      = sel_high && mode;
  assign commit_word = {wr_data[9], wr_data[8], wr_data[7:0], low_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= 1'b0;
      idx   <= '0;
      low_q <= '0;
    end else begin
      if (sel_index) begin
        mode <= wr_data[MODE_BIT];
        idx  <= wr_data[IDX_W-1:0];
      end else if (commit) begin
        idx <= (idx == LAST) ? '0 : idx + 1'b1;
      end
      if (sel_low && mode) low_q <= wr_data;
    end
  end
endmodule

// File: rtl/isl_parity.sv
module isl_parity import isl_pkg::*; (
  input  store_word_t word,
  output logic        bad
);
  logic lo_ok, hi_ok;
  assign lo_ok = (even_par(word[HALF_W-1:0]) == word[INSN_W]);
  assign hi_ok = (even_par(word[INSN_W-1:HALF_W]) == word[INSN_W+1]);
  assign bad = !(lo_ok && hi_ok);
endmodule

// File: rtl/isl_store.sv
module isl_store import isl_pkg::*; #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  store_word_t      wdata,
  input  logic [IDX_W-1:0] raddr,
  output store_word_t      rdata
);
  store_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/isl_loader.sv
module isl_loader import isl_pkg::*; #(
  parameter int DEPTH = 512,
  parameter int AW = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              load_mode,
  output logic              par_err,
  input  logic [IDX_W-1:0]  sr_idx,
  output logic [STORE_W-1:0] sr_data
);
  logic accept, wr_en, rd_en;
  logic [IDX_W-1:0] cur_idx;
  logic commit, bad;
  store_word_t commit_word;
  logic [WORD_W-1:0] index_view;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;
  assign rd_en     = accept && !req_write;

  isl_regs #(.DEPTH(DEPTH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(req_addr),
    .wr_data(req_wdata), .mode(load_mode), .idx(cur_idx),
    .commit(commit), .commit_word(commit_word)
  );

  isl_parity u_par (.word(commit_word), .bad(bad));

  isl_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(commit), .waddr(cur_idx), .wdata(commit_word),
    .raddr(sr_idx), .rdata(sr_data)
  );

  always_comb begin
    index_view = WORD_W'(cur_idx);
    index_view[MODE_BIT] = load_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      par_err   <= 1'b0;
    end else begin
      if (rd_en) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= (req_addr == AW'(OFS_INDEX)) ? index_view : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (commit && bad) par_err <= 1'b1;
    end
  end
endmodule

// File: rtl/isl_loader_chk.sv
module isl_loader_chk #(
  parameter int IDX_W = 9,
  parameter int AW = 12,
  parameter int DEPTH = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             load_mode,
  input logic             par_err,
  input logic [IDX_W-1:0] cur_idx
);
  logic hi_wr;
  assign hi_wr = req_valid && req_ready && req_write && (req_addr == AW'(12'h008));

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R9
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err); // R8
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_mode && hi_wr |=> $stable(cur_idx) && !load_mode); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode && hi_wr && (cur_idx != IDX_W'(DEPTH - 1)) |=>
      (cur_idx - $past(cur_idx)) == IDX_W'(1)); // R5
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode && hi_wr && (cur_idx == IDX_W'(DEPTH - 1)) |=>
      cur_idx == '0 && load_mode); // R6
endmodule

bind isl_loader isl_loader_chk #(.IDX_W(IDX_W), .AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .load_mode(load_mode),
  .par_err(par_err), .cur_idx(cur_idx)
);

// File: tb/tb_isl_loader.sv
module tb_isl_loader;
  localparam int DEPTH = 16;
  localparam int AW = 12;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic req_ready, rsp_valid, load_mode, par_err;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic [IDX_W-1:0] sr_idx = '0;
  logic [41:0] sr_data;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  isl_loader #(.DEPTH(DEPTH), .AW(AW)) dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected rsp", 64'(rsp_rdata), 64'hdead);
      else check(tag_q.pop_front(), 64'(rsp_rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic issue(logic wr, logic [AW-1:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic rd_index(string req, logic [31:0] exp);
    exp_q.push_back(exp); tag_q.push_back(req);
    issue(1'b0, 12'h000, 32'h0);
    @(negedge clk);
  endtask

  function automatic logic [31:0] hi_word(logic [39:0] insn, bit flip);
    return {22'b0, (^insn[39:20]) ^ flip, ^insn[19:0], insn[39:32]};
  endfunction

  function automatic logic [41:0] stored(logic [39:0] insn, bit flip);
    return {(^insn[39:20]) ^ flip, ^insn[19:0], insn};
  endfunction

  task automatic load(logic [39:0] insn, bit flip);
    wr(12'h004, insn[31:0]);
    wr(12'h008, hi_word(insn, flip));
  endtask

  task automatic st_chk(string req, int i, logic [41:0] exp);
    sr_idx = IDX_W'(i);
    @(posedge clk);
    @(negedge clk);
    check(req, 64'(sr_data), 64'(exp));
  endtask

  initial begin
    logic [39:0] a, b, c, d, e;
    a = 40'h12_3456_789a; b = 40'hfe_dcba_9876; c = 40'h0f_0f0f_0f0f;
    d = 40'h55_aaaa_5555; e = 40'hc3_1122_3344;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 mode", 64'(load_mode), 64'd0);
    check("R10 perr", 64'(par_err), 64'd0);
    check("R10 rsp_valid", 64'(rsp_valid), 64'd0);
    rd_index("R10 index", 32'h0);
    // R2 enter load mode at index 3
    wr(12'h000, 32'h8000_0003);
    check("R2 mode", 64'(load_mode), 64'd1);
    rd_index("R2 readback", 32'h8000_0003);
    // R4 commit, R5 increment
    load(a, 1'b0);
    st_chk("R4 store a", 3, stored(a, 1'b0));
    rd_index("R5 index step", 32'h8000_0004);
    // R3 low write alone does not touch store
    wr(12'h000, 32'h8000_0003);
    wr(12'h004, b[31:0]);
    st_chk("R3 store kept", 3, stored(a, 1'b0));
    rd_index("R3 index kept", 32'h8000_0003);
    wr(12'h008, hi_word(b, 1'b0));
    st_chk("R4 store b", 3, stored(b, 1'b0));
    check("R8 no err on good parity", 64'(par_err), 64'd0);
    // R6 wrap
    wr(12'h000, 32'h8000_000f);
    load(c, 1'b0);
    st_chk("R6 store last", 15, stored(c, 1'b0));
    rd_index("R6 wrap readback", 32'h8000_0000);
    load(d, 1'b0);
    st_chk("R6 store at 0", 0, stored(d, 1'b0));
    // R7 leave load mode, data writes ignored
    wr(12'h000, 32'h0);
    check("R7 mode off", 64'(load_mode), 64'd0);
    load(e, 1'b0);
    st_chk("R7 store unchanged", 0, stored(d, 1'b0));
    rd_index("R7 index unchanged", 32'h0);
    // R1 undecoded offset ignored
    wr(12'h000, 32'h8000_0005);
    wr(12'h00c, 32'h0000_00ff);
    rd_index("R1 stray offset", 32'h8000_0005);
    // R9 back-pressure
    rsp_ready = 1'b0;
    exp_q.push_back(32'h8000_0005); tag_q.push_back("R9 held response");
    issue(1'b0, 12'h000, 32'h0);
    check("R9 ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    check("R9 data held", 64'(rsp_rdata), 64'h8000_0005);
    check("R9 still valid", 64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R8 parity mismatch stored, sticky
    load(e, 1'b1);
    st_chk("R8 bad word stored", 5, stored(e, 1'b1));
    check("R8 flag set", 64'(par_err), 64'd1);
    load(a, 1'b0);
    check("R8 flag sticky", 64'(par_err), 64'd1);
    check("R9 queue drained", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule